// File: doc/BRIEF.md
# Two-Arm Signal Phase Sequencer

This block steps the lamps of a two-arm road junction through a fixed order of phases. Each arm is served in turn: a straight-and-right green, a yellow, a protected left-turn arrow shown over red, and a second yellow. Service then passes to the other arm while the waiting arm stays red. An external timing controller decides when a green or left-turn phase has lasted long enough and sends a one-cycle switch request. The yellow intervals time themselves from a phase tick strobe.

A pedestrian button press is remembered. It is served once, as a walk phase with both arms red, at the point where the second arm's service ends. A synchronous reset, including the one at power-up, returns the block to the first arm's green with no walk pending.

Top module: `signal_phase_seq`

## Requirements
- R1: While `rst` is high the next clock edge gives `lamp_a`=4'b0100 (green), `lamp_b`=4'b0001 (red), `arm`=0, `phase`=0, `walk`=0, and any remembered pedestrian press is discarded.
- R2: In phase 0 (green) or phase 2 (left turn) the state holds while `switch_req` is 0, and advances to the next phase on the edge where `switch_req` is 1. `tick` has no effect in these phases.
- R3: A yellow phase (1 or 3) lasts exactly two cycles with `tick` high. Cycles without `tick` do not count, and `switch_req` has no effect during yellow.
- R4: The served arm goes through phase 0, 1, 2, 3. After phase 3 of arm 0, arm 1 starts at phase 0. The arm that is not served shows red (4'b0001).
- R5: A `ped_btn` press is remembered. When arm 1 leaves phase 3 with a press remembered, `walk` goes to 1 with both lamps red, and `arm`/`phase` hold at 1/3. Without a remembered press, arm 0 starts at phase 0.
- R6: The remembered press is cleared when the walk phase is entered. A press during the walk phase is remembered and served at the end of the next full cycle.
- R7: The walk phase holds while `switch_req` is 0. On `switch_req`=1 it ends, and the block returns to arm 0, phase 0.
- R8: The lamp code per arm is red 4'b0001, yellow 4'b0010, green 4'b0100 and left arrow over red 4'b1001. Green or arrow is never lit on both arms in the same cycle.
- R9: The lamp outputs are registered and change on the same clock edge as `arm`, `phase` and `walk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| switch_req | input | 1 | one-cycle request to leave green, left turn or walk |
| ped_btn | input | 1 | pedestrian button |
| tick | input | 1 | phase timer strobe |
| lamp_a | output | 4 | lamp code of arm 0 |
| lamp_b | output | 4 | lamp code of arm 1 |
| arm | output | 1 | arm being served |
| phase | output | 2 | phase of the served arm |
| walk | output | 1 | pedestrian walk phase active |

## Verification
A wrong phase or arm register shows at the lamp outputs on the very next edge, because the lamps are decoded from the same next-state value that loads those registers. A yellow timer that miscounts shows as a yellow that ends one tick early or late, so the bench steps through every yellow tick by tick with idle cycles between ticks. A pedestrian latch that fails to set, clear or relatch shows only at the end of a cycle, as a missing or extra walk phase. For that reason the stimulus runs three full cycles: one with a press pending, one with a press made during walk, and one with no press.

// File: rtl/signal_phase_seq.sv
module signal_phase_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       switch_req,
  input  logic       ped_btn,
  input  logic       tick,
  output logic [3:0] lamp_a,
  output logic [3:0] lamp_b,
  output logic       arm,
  output logic [1:0] phase,
  output logic       walk
);
  localparam logic [3:0] L_RED = 4'b0001;
  localparam logic [3:0] L_YEL = 4'b0010;
  localparam logic [3:0] L_GRN = 4'b0100;
  localparam logic [3:0] L_ARW = 4'b1001;
  localparam logic [1:0] YEL_LAST = 2'd1;

  logic       pend, pend_n;
  logic [1:0] tmr, tmr_n;
  logic       arm_n, walk_n;
  logic [1:0] ph_n;

  function automatic logic [3:0] decode(input logic served, input logic [1:0] ph);
    if (!served) return L_RED;
    case (ph)
      2'd0:    return L_GRN;
      2'd2:    return L_ARW;
      default: return L_YEL;
    endcase
  endfunction

  always_comb begin
    arm_n  = arm;
    ph_n   = phase;
    walk_n = walk;
    tmr_n  = tmr;
    if (walk) begin
      if (switch_req) begin
        walk_n = 1'b0;
        arm_n  = 1'b0;
        ph_n   = 2'd0;
      end
    end else if (!phase[0]) begin
      if (switch_req) ph_n = phase + 2'd1;
    end else if (tick) begin
      if (tmr == YEL_LAST) begin
        ph_n = phase + 2'd1;
        if (phase == 2'd3) begin
          if (!arm)      arm_n = 1'b1;
          else if (pend) begin
            walk_n = 1'b1;
            ph_n   = phase;
          end else       arm_n = 1'b0;
        end
      end else tmr_n = tmr + 2'd1;
    end
    if (ph_n != phase || arm_n != arm || walk_n != walk) tmr_n = 2'd0;
  end

  assign pend_n = ped_btn | (pend & ~(walk_n & ~walk));

  always_ff @(posedge clk) begin
    if (rst) begin
      arm    <= 1'b0;
      phase  <= 2'd0;
      walk   <= 1'b0;
      pend   <= 1'b0;
      tmr    <= 2'd0;
      lamp_a <= L_GRN;
      lamp_b <= L_RED;
    end else begin
      arm    <= arm_n;
      phase  <= ph_n;
      walk   <= walk_n;
      pend   <= pend_n;
      tmr    <= tmr_n;
      lamp_a <= decode(!walk_n && !arm_n, ph_n);
      lamp_b <= decode(!walk_n &&  arm_n, ph_n);
    end
  end

  // R8
  no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    !((lamp_a[2] | lamp_a[3]) && (lamp_b[2] | lamp_b[3])));

  // R8
  lamp_code_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(lamp_a & 4'b0111) && $onehot(lamp_b & 4'b0111));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!walk && !phase[0] && !switch_req) |=> ($stable(phase) && $stable(arm) && $stable(lamp_a)));

  // R3
  yellow_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!walk && phase[0] && !tick) |=> ($stable(phase) && $stable(arm) && $stable(walk)));

  // R5
  walk_red_chk: assert property (@(posedge clk) disable iff (rst)
    walk |-> (lamp_a == L_RED && lamp_b == L_RED));

  // R6
  walk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(walk) && !$past(ped_btn)) |-> !pend);

  // R7
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (walk && !switch_req) |=> walk);
endmodule

// File: tb/signal_phase_seq_test.sv
module signal_phase_seq_test;
  localparam int PERIOD = 10;
  localparam logic [3:0] R = 4'b0001;
  localparam logic [3:0] Y = 4'b0010;
  localparam logic [3:0] G = 4'b0100;
  localparam logic [3:0] L = 4'b1001;
  localparam int NV = 43;
  // {req, sw/ped/tick, lamp_a, lamp_b, walk/arm/phase}
  localparam logic [18:0] VEC [NV] = '{
    {4'd2, 3'b001, G, R, 4'b0000},
    {4'd2, 3'b100, Y, R, 4'b0001},
    {4'd3, 3'b001, Y, R, 4'b0001},
    {4'd3, 3'b000, Y, R, 4'b0001},
    {4'd3, 3'b100, Y, R, 4'b0001},
    {4'd4, 3'b001, L, R, 4'b0010},
    {4'd2, 3'b001, L, R, 4'b0010},
    {4'd5, 3'b110, Y, R, 4'b0011},
    {4'd3, 3'b001, Y, R, 4'b0011},
    {4'd4, 3'b001, R, G, 4'b0100},
    {4'd4, 3'b100, R, Y, 4'b0101},
    {4'd3, 3'b001, R, Y, 4'b0101},
    {4'd4, 3'b001, R, L, 4'b0110},
    {4'd4, 3'b100, R, Y, 4'b0111},
    {4'd3, 3'b001, R, Y, 4'b0111},
    {4'd5, 3'b001, R, R, 4'b1111},
    {4'd6, 3'b010, R, R, 4'b1111},
    {4'd7, 3'b100, G, R, 4'b0000},
    {4'd6, 3'b100, Y, R, 4'b0001},
    {4'd3, 3'b001, Y, R, 4'b0001},
    {4'd4, 3'b001, L, R, 4'b0010},
    {4'd4, 3'b100, Y, R, 4'b0011},
    {4'd3, 3'b001, Y, R, 4'b0011},
    {4'd4, 3'b001, R, G, 4'b0100},
    {4'd4, 3'b100, R, Y, 4'b0101},
    {4'd3, 3'b001, R, Y, 4'b0101},
    {4'd4, 3'b001, R, L, 4'b0110},
    {4'd4, 3'b100, R, Y, 4'b0111},
    {4'd3, 3'b001, R, Y, 4'b0111},
    {4'd6, 3'b001, R, R, 4'b1111},
    {4'd7, 3'b100, G, R, 4'b0000},
    {4'd9, 3'b100, Y, R, 4'b0001},
    {4'd3, 3'b001, Y, R, 4'b0001},
    {4'd4, 3'b001, L, R, 4'b0010},
    {4'd4, 3'b100, Y, R, 4'b0011},
    {4'd3, 3'b001, Y, R, 4'b0011},
    {4'd4, 3'b001, R, G, 4'b0100},
    {4'd4, 3'b100, R, Y, 4'b0101},
    {4'd3, 3'b001, R, Y, 4'b0101},
    {4'd4, 3'b001, R, L, 4'b0110},
    {4'd4, 3'b100, R, Y, 4'b0111},
    {4'd3, 3'b001, R, Y, 4'b0111},
    {4'd5, 3'b001, G, R, 4'b0000}
  };
  // tags: R2 hold, R3 yellow, R4 order, R5 walk, R6 relatch, R7 walk exit, R8 codes, R9 same-edge

  logic clk = 1'b0, rst = 1'b1, switch_req = 1'b0, ped_btn = 1'b0, tick = 1'b0;
  logic [3:0] lamp_a, lamp_b;
  logic arm, walk;
  logic [1:0] phase;
  int checks = 0, fails = 0;

  signal_phase_seq uut (.clk(clk), .rst(rst), .switch_req(switch_req), .ped_btn(ped_btn),
    .tick(tick), .lamp_a(lamp_a), .lamp_b(lamp_b), .arm(arm), .phase(phase), .walk(walk));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input int req, input logic [14:0] exp);
    logic [14:0] act;
    act = {3'b000, lamp_a, lamp_b, walk, arm, phase};
    checks++;
    if (act[11:0] != exp[11:0]) begin
      fails++;
      $display("FAIL R%0d: lamps/walk/arm/phase got %b expected %b", req, act[11:0], exp[11:0]);
    end
  endtask

  task automatic step(input logic [2:0] in);
    {switch_req, ped_btn, tick} = in;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2;
    step(3'b000);
    step(3'b000);
    rst = 1'b0;
    check(1, {3'b0, G, R, 4'b0000}); // R1 reset state
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14:12]);
      check(int'(VEC[i][18:15]), VEC[i][14:0]);
    end
    // R1: reset mid-yellow with a pending press
    step(3'b100);
    step(3'b010);
    check(3, {3'b0, Y, R, 4'b0001});
    rst = 1'b1;
    step(3'b001);
    rst = 1'b0;
    check(1, {3'b0, G, R, 4'b0000});
    for (int c = 0; c < 2; c++) begin
      step(3'b100); step(3'b001); step(3'b001); step(3'b100); step(3'b001); step(3'b001);
    end
    check(1, {3'b0, G, R, 4'b0000}); // R1: press discarded by reset, no walk
    // R3: many idle cycles in yellow do not end it
    step(3'b100);
    for (int k = 0; k < 5; k++) step(3'b100);
    check(3, {3'b0, Y, R, 4'b0001});
    step(3'b001);
    step(3'b000);
    check(3, {3'b0, Y, R, 4'b0001});
    step(3'b001);
    check(3, {3'b0, L, R, 4'b0010});
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule